// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the source and destination addresses of one DMA channel. Each side has a live 24-bit address counter and a starting-address register. Each side also has its own step mode and its own reload policy. One 8-bit control register holds all four settings. The counters move when a per-side beat strobe arrives. They return to the starting value when an event pulse matches the chosen reload boundary: end of burst, end of block or end of transaction.

The surrounding channel logic drives the event pulses and a busy flag. While busy is high, the control register and both starting-address registers are frozen, and any write to them is dropped. While the channel is idle, writing a starting address also loads that side's live counter. The channel therefore begins at the programmed value.

Top module: `dma_agen`

## Requirements
- R1: The control register reads back on `ctrl_o` with this layout: [7:6] source reload, [5:4] source direction, [3:2] destination reload, [1:0] destination direction. A write with `ctrl_we_i` while idle takes effect on the next clock edge.
- R2: A control write while `busy_i` is high is ignored, and `ctrl_o` keeps its value.
- R3: Direction code 01 adds one to the address on each beat of that side. The address wraps from FFFFFF to 000000.
- R4: Direction code 10 subtracts one from the address on each beat of that side. The address wraps from 000000 to FFFFFF.
- R5: Direction code 00 (fixed) and the reserved code 11 leave the address unchanged on a beat.
- R6: Reload code 01 restores the address to the starting value on an end-of-block pulse. Reload code 10 does so on an end-of-burst pulse. Reload code 00 never restores it. An end-of-burst pulse does not trigger block reload, and an end-of-block pulse does not trigger burst reload.
- R7: An end-of-transaction pulse restores the address for every reload code other than 00, including code 11.
- R8: When a reload and a beat fall in the same cycle, the address takes the starting value and is not stepped.
- R9: A starting-address write while idle sets both the starting value and the live address. While busy, such a write is ignored, and a later reload still restores the old value.
- R10: The source and destination sides use their own fields and strobes, and one side's settings never move the other's address.
- R11: Reset (`rst_ni` low) clears the control register and both addresses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Channel running; freezes configuration |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| src_start_we_i | input | 1 | Source starting-address write strobe |
| src_start_wdata_i | input | 24 | Source starting-address write data |
| dst_start_we_i | input | 1 | Destination starting-address write strobe |
| dst_start_wdata_i | input | 24 | Destination starting-address write data |
| src_beat_i | input | 1 | Source beat strobe |
| dst_beat_i | input | 1 | Destination beat strobe |
| burst_end_i | input | 1 | End-of-burst pulse |
| block_end_i | input | 1 | End-of-block pulse |
| xfer_end_i | input | 1 | End-of-transaction pulse |
| ctrl_o | output | 8 | Control register contents |
| src_addr_o | output | 24 | Current source address |
| dst_addr_o | output | 24 | Current destination address |

## Verification
A beat step and a reload can land on the same edge. The bench provokes this by raising a beat strobe together with the matching boundary pulse, for both sides and for each reload code. The behavioural model in the bench lets the reload take priority, and it compares both addresses against the model on every clock. A second collision, a starting-address write arriving together with busy, is judged later by firing a reload and checking that the address returns to the old starting value.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  localparam int unsigned ADDR_W = 24;

  typedef enum logic [1:0] {
    RLD_NONE  = 2'b00,
    RLD_BLOCK = 2'b01,
    RLD_BURST = 2'b10,
    RLD_XFER  = 2'b11
  } reload_e;

  typedef enum logic [1:0] {
    DIR_FIXED = 2'b00,
    DIR_INC   = 2'b01,
    DIR_DEC   = 2'b10,
    DIR_RSVD  = 2'b11
  } dir_e;

  // packed MSB-first: matches register bit positions
  typedef struct packed {
    reload_e src_rld;
    dir_e    src_dir;
    reload_e dst_rld;
    dir_e    dst_dir;
  } addr_ctrl_t;
endpackage

// File: rtl/dma_agen_ctrl.sv
module dma_agen_ctrl
  import dma_agen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output addr_ctrl_t ctrl_o
);
  addr_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (we_i && !busy_i) ctrl_q <= addr_ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ctrl_q)); // R2
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_i) |=> (ctrl_q == $past(wdata_i))); // R1
endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
  import dma_agen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          start_we_i,
  input  logic [AW-1:0] start_wdata_i,
  input  logic          beat_i,
  input  logic          burst_end_i,
  input  logic          block_end_i,
  input  logic          xfer_end_i,
  input  reload_e       rld_i,
  input  dir_e          dir_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] start_q, addr_q, addr_step;
  logic          load_start, reload_hit;

  assign load_start = start_we_i && !busy_i;

  // transaction end implies block and burst end
  always_comb begin
    unique case (rld_i)
      RLD_BLOCK: reload_hit = block_end_i || xfer_end_i;
      RLD_BURST: reload_hit = burst_end_i || xfer_end_i;
      RLD_XFER:  reload_hit = xfer_end_i;
      default:   reload_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (dir_i)
      DIR_INC: addr_step = addr_q + AW'(1);
      DIR_DEC: addr_step = addr_q - AW'(1);
      default: addr_step = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      addr_q  <= '0;
    end else if (load_start) begin
      start_q <= start_wdata_i;
      addr_q  <= start_wdata_i;
    end else if (reload_hit) begin
      addr_q  <= start_q;
    end else if (beat_i) begin
      addr_q  <= addr_step;
    end
  end

  assign addr_o = addr_q;

  AST_START_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(start_q)); // R9
  AST_RELOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_end_i && rld_i != RLD_NONE && !load_start) |=> (addr_o == $past(start_q))); // R8
  AST_FIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_i == DIR_FIXED || dir_i == DIR_RSVD) && !load_start && !reload_hit)
      |=> $stable(addr_o)); // R5
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && dir_i == DIR_INC && !load_start && !reload_hit)
      |=> (addr_o == $past(addr_o) + AW'(1))); // R3
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && dir_i == DIR_DEC && !load_start && !reload_hit)
      |=> (addr_o == $past(addr_o) - AW'(1))); // R4
endmodule

// File: rtl/dma_agen.sv
module dma_agen
  import dma_agen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_wdata_i,
  input  logic          src_start_we_i,
  input  logic [AW-1:0] src_start_wdata_i,
  input  logic          dst_start_we_i,
  input  logic [AW-1:0] dst_start_wdata_i,
  input  logic          src_beat_i,
  input  logic          dst_beat_i,
  input  logic          burst_end_i,
  input  logic          block_end_i,
  input  logic          xfer_end_i,
  output logic [7:0]    ctrl_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o
);
  localparam int unsigned NSIDE = 2; // 0: source, 1: destination

  addr_ctrl_t    ctrl;
  logic          side_we    [NSIDE];
  logic [AW-1:0] side_wdata [NSIDE];
  logic          side_beat  [NSIDE];
  reload_e       side_rld   [NSIDE];
  dir_e          side_dir   [NSIDE];
  logic [AW-1:0] side_addr  [NSIDE];

  dma_agen_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_i),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  assign side_we[0]    = src_start_we_i;
  assign side_we[1]    = dst_start_we_i;
  assign side_wdata[0] = src_start_wdata_i;
  assign side_wdata[1] = dst_start_wdata_i;
  assign side_beat[0]  = src_beat_i;
  assign side_beat[1]  = dst_beat_i;
  assign side_rld[0]   = ctrl.src_rld;
  assign side_rld[1]   = ctrl.dst_rld;
  assign side_dir[0]   = ctrl.src_dir;
  assign side_dir[1]   = ctrl.dst_dir;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_agen_side #(.AW(AW)) u_side (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .busy_i        (busy_i),
      .start_we_i    (side_we[g]),
      .start_wdata_i (side_wdata[g]),
      .beat_i        (side_beat[g]),
      .burst_end_i   (burst_end_i),
      .block_end_i   (block_end_i),
      .xfer_end_i    (xfer_end_i),
      .rld_i         (side_rld[g]),
      .dir_i         (side_dir[g]),
      .addr_o        (side_addr[g])
    );
  end

  assign ctrl_o     = ctrl;
  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];

  AST_SRC_INDEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_beat_i && !src_start_we_i && !burst_end_i && !block_end_i && !xfer_end_i)
      |=> $stable(src_addr_o)); // R10
endmodule

// File: tb/dma_agen_test.sv
module dma_agen_test;
  localparam int PERIOD = 10;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic busy = 0, ctrl_we = 0, s_we = 0, d_we = 0;
  logic [7:0] ctrl_wd = 0;
  logic [AW-1:0] s_wd = 0, d_wd = 0;
  logic s_beat = 0, d_beat = 0, burst = 0, block = 0, xfer = 0;
  logic [7:0] ctrl_o;
  logic [AW-1:0] src_o, dst_o;

  int checks = 0, errors = 0;
  string tag = "R11";
  bit done = 0;

  logic [7:0]    m_ctrl;
  logic [AW-1:0] m_addr [2];
  logic [AW-1:0] m_start [2];

  always #(PERIOD/2) clk = ~clk;

  dma_agen uut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .src_start_we_i(s_we), .src_start_wdata_i(s_wd),
    .dst_start_we_i(d_we), .dst_start_wdata_i(d_wd),
    .src_beat_i(s_beat), .dst_beat_i(d_beat),
    .burst_end_i(burst), .block_end_i(block), .xfer_end_i(xfer),
    .ctrl_o(ctrl_o), .src_addr_o(src_o), .dst_addr_o(dst_o)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("ctrl", 32'(ctrl_o), 32'(m_ctrl));
    check("src", 32'(src_o), 32'(m_addr[0]));
    check("dst", 32'(dst_o), 32'(m_addr[1]));
  endtask

  // behavioural model of one clock edge
  task automatic model();
    logic [7:0] c;
    c = m_ctrl;
    if (ctrl_we && !busy) m_ctrl = ctrl_wd;
    for (int s = 0; s < 2; s++) begin
      int rld, dir;
      bit hit, we, bt;
      logic [AW-1:0] wd;
      rld = (s == 0) ? int'(c[7:6]) : int'(c[3:2]);
      dir = (s == 0) ? int'(c[5:4]) : int'(c[1:0]);
      we  = (s == 0) ? s_we : d_we;
      wd  = (s == 0) ? s_wd : d_wd;
      bt  = (s == 0) ? s_beat : d_beat;
      hit = (rld != 0 && xfer) || (rld == 1 && block) || (rld == 2 && burst);
      if (we && !busy) begin
        m_start[s] = wd; m_addr[s] = wd;
      end else if (hit) m_addr[s] = m_start[s];
      else if (bt) begin
        if (dir == 1) m_addr[s] = m_addr[s] + 1;
        else if (dir == 2) m_addr[s] = m_addr[s] - 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    ctrl_we = 0; s_we = 0; d_we = 0;
    s_beat = 0; d_beat = 0; burst = 0; block = 0; xfer = 0;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_we = 1; ctrl_wd = v; tick();
  endtask

  task automatic wr_start(logic [AW-1:0] s, logic [AW-1:0] d);
    s_we = 1; s_wd = s; d_we = 1; d_wd = d; tick();
  endtask

  task automatic beats(int n, bit sb, bit db);
    for (int i = 0; i < n; i++) begin
      s_beat = sb; d_beat = db; tick();
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_ctrl = 0; m_addr[0] = 0; m_addr[1] = 0; m_start[0] = 0; m_start[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R11"; tick();

    tag = "R1"; wr_ctrl(8'b00_01_00_10);
    check("layout", 32'(ctrl_o), 32'h12);

    tag = "R3"; wr_start(24'hFFFFFE, 24'h000001);
    beats(4, 1, 0);
    tag = "R4"; beats(4, 0, 1);

    tag = "R10"; beats(3, 1, 0);
    check("dst unmoved", 32'(dst_o), 32'hFFFFFD);

    tag = "R2"; busy = 1; wr_ctrl(8'hFF); beats(2, 1, 1);
    tag = "R9"; wr_start(24'h123456, 24'h654321);
    busy = 0;

    tag = "R5"; wr_ctrl(8'b00_00_00_11); beats(3, 1, 1);

    tag = "R6"; wr_start(24'h000100, 24'h000200);
    wr_ctrl(8'b01_01_10_10);
    beats(5, 1, 1);
    burst = 1; tick();
    block = 1; tick();
    beats(2, 1, 1);
    wr_ctrl(8'b00_01_00_01); beats(2, 1, 1);
    burst = 1; block = 1; tick();

    tag = "R7"; wr_ctrl(8'b11_01_11_10);
    beats(3, 1, 1);
    burst = 1; block = 1; tick();
    xfer = 1; tick();
    wr_ctrl(8'b01_01_10_01); beats(2, 1, 1); xfer = 1; tick();

    tag = "R8"; beats(3, 1, 1);
    xfer = 1; s_beat = 1; d_beat = 1; tick();
    check("src start", 32'(src_o), 32'h000100);
    beats(2, 1, 1);
    block = 1; s_beat = 1; d_beat = 1; tick();
    burst = 1; s_beat = 1; d_beat = 1; tick();

    tag = "R9"; busy = 1;
    wr_start(24'hABCDEF, 24'hFEDCBA);
    beats(2, 1, 1);
    xfer = 1; tick();
    check("old start kept", 32'(src_o), 32'h000100);
    busy = 0;
    wr_start(24'h000000, 24'hFFFFFF);
    wr_ctrl(8'b00_10_00_01); beats(1, 1, 1);
    check("src wrap", 32'(src_o), 32'hFFFFFF);
    check("dst wrap", 32'(dst_o), 32'h000000);

    tag = "R11"; rst_n = 0; @(negedge clk);
    m_ctrl = 0; m_addr[0] = 0; m_addr[1] = 0; m_start[0] = 0; m_start[1] = 0;
    compare();
    rst_n = 1; tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule